// File: doc/BRIEF.md
# Parked Address Bus Arbiter

This block decides which of several bus masters may start an address tenure on a split-transaction processor bus. Every master has its own request line and its own grant line. All masters share one transfer-start strobe, and the arbiter drives the address-acknowledge strobe that closes each tenure. A master counts its grant as usable in any cycle where that grant is high and transfer-start is low. In the next cycle it may drive transfer-start.

When no other master is asking for the bus, the grant stays parked on the current owner. That owner can then start tenures without a request/grant round trip. When some other master requests, the arbiter moves the grant to it in the following cycle. The cycle after that, the arbiter pulls the new grant low. It holds the grant low until the acknowledge for every tenure already started has been driven, and then restores it. This keeps the incoming master from overlapping the tail of the outgoing tenure, and the arbiter never has to react to transfer-start within the same cycle it swaps the grants. After the hand-over the grant parks on the new master.

If several masters compete, the winner is chosen round-robin, starting after the current owner. The acknowledge latency is a parameter. A second parameter delays the return of the grant by one more cycle, for systems that cannot predict the acknowledge cycle.

Top module: `abus_park_arb`

## Requirements
- R1: While reset is active, and right after it is released, `grant` is 4'b0001 (parked on master 0) and `addr_ack` is low.
- R2: At most one bit of `grant` is high in any cycle.
- R3: A parked grant stays unchanged while no master other than the owner requests. A request from the owner itself has no effect.
- R4: With ACK_LAT = 1, a request from a non-owner sampled in a cycle where the grant is parked moves the grant to that requester in the next cycle. Requests seen in that swap cycle are ignored.
- R5: In the cycle after the grant moves to a new master, every grant bit is low. This holds whether or not transfer-start was seen in the swap cycle.
- R6: After that gap, the grant comes back on the new owner in the first cycle after the acknowledge of the last tenure started so far. If no tenure is open, it comes back directly after the single gap cycle. With GRANT_SLIP = 1, it comes back one cycle later than that.
- R7: For each cycle with transfer-start high, `addr_ack` is high for exactly one cycle, ACK_LAT cycles later. `addr_ack` is low at all other times.
- R8: Among competing requesters, the winner is the first requesting index after the owner, in ascending order and wrapping from NUM_MASTERS-1 to 0.
- R9: With default parameters, a request sampled while the parked owner starts a tenure leads to the new master's first transfer-start exactly four cycles later.
- R10: Masters that obey the usable-grant rule never start a tenure while an earlier tenure is still waiting for its acknowledge.
- R11: With ACK_LAT > 1, a hand-over is held back while any tenure already started would be acknowledged later than the cycle after the decision. The grant stays on the owner until that is no longer the case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | One bus request per master |
| xfer_start | input | 1 | Shared transfer-start strobe driven by the master that opens a tenure |
| grant | output | NUM_MASTERS | One address bus grant per master, at most one high |
| addr_ack | output | 1 | Address acknowledge that closes a tenure |

## Verification
If the hand-over state is wrong, the grant lines show it within one or two cycles of a swap. Examples are a gap cycle that never appears, a gap that does not end, or a grant that comes back before the outgoing acknowledge. A wrong owner index shows up as the grant landing on a master that is not next in round-robin order. A corrupted acknowledge pipeline shows up as `addr_ack` missing or misplaced relative to transfer-start. It also shows up indirectly, because the grant comes back too early or too late. The bench models the masters' usable-grant rule, so a premature grant appears as an overlapping transfer-start in the very next cycle.

// File: rtl/abus_park_arb.sv
`timescale 1ns/1ps
module abus_park_arb #(
  parameter int NUM_MASTERS = 4,
  parameter int ACK_LAT     = 1,
  parameter int GRANT_SLIP  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   xfer_start,
  output logic [NUM_MASTERS-1:0] grant,
  output logic                   addr_ack
);

  localparam int IDX_W = $clog2(NUM_MASTERS);

  function automatic logic [ACK_LAT-1:0] low_ones(input int n);
    logic [ACK_LAT-1:0] m;
    for (int i = 0; i < ACK_LAT; i++) m[i] = (i < n);
    return m;
  endfunction

  // Tenures whose acknowledge falls after the cycle following a swap decision.
  localparam logic [ACK_LAT-1:0] LATE_MASK = low_ones(ACK_LAT - 2);
  // Tenures that still keep the grant withheld during the gap.
  localparam logic [ACK_LAT-1:0] HOLD_MASK =
    (GRANT_SLIP != 0) ? low_ones(ACK_LAT) : low_ones(ACK_LAT - 1);

  typedef enum logic [1:0] {ST_PARK, ST_SWAP, ST_GAP} arb_st_t;

  arb_st_t            state;
  logic [IDX_W-1:0]   owner;
  logic [ACK_LAT-1:0] ack_pipe;
  logic [IDX_W:0]     pick;
  logic               late, busy;

  function automatic logic [IDX_W:0] rr_pick(input logic [IDX_W-1:0] cur,
                                             input logic [NUM_MASTERS-1:0] r);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = NUM_MASTERS - 1; k >= 1; k--)
      if (r[(int'(cur) + k) % NUM_MASTERS])
        res = {1'b1, IDX_W'((int'(cur) + k) % NUM_MASTERS)};
    return res;
  endfunction

  assign pick     = rr_pick(owner, req);
  assign late     = ((ACK_LAT > 1) && xfer_start) || (|(ack_pipe & LATE_MASK));
  assign busy     = xfer_start || (|(ack_pipe & HOLD_MASK));
  assign addr_ack = ack_pipe[ACK_LAT-1];
  assign grant    = (state == ST_GAP) ? '0 : (NUM_MASTERS'(1) << owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PARK;
      owner    <= '0;
      ack_pipe <= '0;
    end else begin
      ack_pipe <= (ack_pipe << 1) | ACK_LAT'(xfer_start);
      case (state)
        ST_PARK: if (pick[IDX_W] && !late) begin
          owner <= pick[IDX_W-1:0];
          state <= ST_SWAP;
        end
        ST_SWAP: state <= ST_GAP;
        default: if (!busy) state <= ST_PARK;
      endcase
    end
  end

endmodule

// File: rtl/abus_park_arb_chk.sv
`timescale 1ns/1ps
module abus_park_arb_chk #(
  parameter int NUM_MASTERS = 4,
  parameter int ACK_LAT     = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_MASTERS-1:0] req,
  input logic                   xfer_start,
  input logic [NUM_MASTERS-1:0] grant,
  input logic                   addr_ack
);

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && $stable(grant) && (req & ~grant) == '0) |=> $stable(grant)); // R3

  AST_GAP_AFTER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && $past(grant) != '0 && grant != $past(grant)) |=> (grant == '0)); // R5

  AST_HOLD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && xfer_start) |=> (grant == '0)); // R6

  generate
    if (ACK_LAT == 1) begin : g_lat1
      AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> addr_ack); // R7
      AST_SWAP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && $stable(grant) && (req & ~grant) != '0)
        |=> (grant != '0 && grant != $past(grant))); // R4
    end else if (ACK_LAT == 2) begin : g_lat2
      AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ##2 addr_ack); // R7
    end
  endgenerate

endmodule

bind abus_park_arb abus_park_arb_chk #(
  .NUM_MASTERS(NUM_MASTERS),
  .ACK_LAT    (ACK_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .xfer_start(xfer_start),
  .grant     (grant),
  .addr_ack  (addr_ack)
);

// File: tb/abus_park_arb_tb.sv
`timescale 1ns/1ps
module abus_park_arb_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_a, want_a, grant_a;
  logic [3:0] req_b, want_b, grant_b;
  logic       ts_a, ack_a, ts_b, ack_b;
  int         total = 0;
  int         bad = 0;
  int         overlap_a = 0;
  logic       open_a;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  abus_park_arb #(.NUM_MASTERS(4), .ACK_LAT(1), .GRANT_SLIP(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req_a), .xfer_start(ts_a),
    .grant(grant_a), .addr_ack(ack_a));

  abus_park_arb #(.NUM_MASTERS(4), .ACK_LAT(2), .GRANT_SLIP(1)) u_dut_slip (
    .clk(clk), .rst_n(rst_n), .req(req_b), .xfer_start(ts_b),
    .grant(grant_b), .addr_ack(ack_b));

  // Master model: a master with a tenure ready starts it the cycle after a usable grant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_a <= 1'b0;
      ts_b <= 1'b0;
    end else begin
      ts_a <= (|(grant_a & want_a)) && !ts_a;
      ts_b <= (|(grant_b & want_b)) && !ts_b;
    end
  end

  // R10 monitor: a start while an earlier tenure awaits its acknowledge.
  always @(negedge clk) begin
    if (!rst_n) open_a = 1'b0;
    else begin
      if (ts_a && open_a) overlap_a++;
      if (ts_a) open_a = 1'b1;
      else if (ack_a) open_a = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_b(input logic [3:0] eg, input logic ets, input logic eack,
                        input logic [3:0] nreq, input logic [3:0] nwant, input string tag);
    @(negedge clk);
    chk({tag, " grant"}, 32'(grant_b), 32'(eg));
    chk({tag, " start"}, 32'(ts_b), 32'(ets));
    chk({tag, " ack"}, 32'(ack_b), 32'(eack));
    req_b  = nreq;
    want_b = nwant;
  endtask

  // {tag, req, want, expected grant, expected start, expected ack}
  localparam logic [17:0] VEC [0:25] = '{
    {4'd1,  4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // R1 idle after reset
    {4'd4,  4'b0010, 4'b0001, 4'b0001, 1'b0, 1'b0}, // R4 request while owner starts
    {4'd4,  4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b0}, // R4 swapped; outgoing start
    {4'd5,  4'b0000, 4'b0010, 4'b0000, 1'b0, 1'b1}, // R5 gap, R7 ack
    {4'd6,  4'b0000, 4'b0010, 4'b0010, 1'b0, 1'b0}, // R6 grant back after ack
    {4'd9,  4'b0000, 4'b0010, 4'b0010, 1'b1, 1'b0}, // R9 new master starts
    {4'd7,  4'b0000, 4'b0010, 4'b0010, 1'b0, 1'b1}, // R7
    {4'd3,  4'b0000, 4'b0000, 4'b0010, 1'b1, 1'b0}, // R3 back-to-back on parked grant
    {4'd3,  4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b1}, // R3
    {4'd8,  4'b1101, 4'b0000, 4'b0010, 1'b0, 1'b0}, // R8 owner 1, pick 2
    {4'd8,  4'b1001, 4'b0000, 4'b0100, 1'b0, 1'b0}, // R8
    {4'd5,  4'b1001, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R5
    {4'd6,  4'b1001, 4'b0000, 4'b0100, 1'b0, 1'b0}, // R6 no open tenure
    {4'd8,  4'b0001, 4'b0000, 4'b1000, 1'b0, 1'b0}, // R8 owner 2, pick 3
    {4'd5,  4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R5
    {4'd6,  4'b0001, 4'b0000, 4'b1000, 1'b0, 1'b0}, // R6
    {4'd8,  4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // R8 wrap to 0
    {4'd5,  4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R5
    {4'd6,  4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // R6
    {4'd3,  4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b0}, // R3 owner request ignored
    {4'd3,  4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0}, // R3
    {4'd4,  4'b0010, 4'b0010, 4'b0001, 1'b0, 1'b0}, // R4 nothing outgoing
    {4'd4,  4'b0000, 4'b0010, 4'b0010, 1'b0, 1'b0}, // R4 new master usable at once
    {4'd5,  4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R5 start in gap
    {4'd6,  4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1}, // R6 held until ack
    {4'd6,  4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b0}  // R6
  };

  initial begin
    rst_n = 1'b0; req_a = '0; want_a = '0; req_b = '0; want_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", 32'(grant_a), 32'h1);
    chk("R1 ack in reset", 32'(ack_a), 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < 26; v++) begin
      @(negedge clk);
      chk($sformatf("R%0d vec%0d grant", VEC[v][17:14], v), 32'(grant_a), 32'(VEC[v][5:2]));
      chk($sformatf("R%0d vec%0d start", VEC[v][17:14], v), 32'(ts_a), 32'(VEC[v][1]));
      chk($sformatf("R%0d vec%0d ack", VEC[v][17:14], v), 32'(ack_a), 32'(VEC[v][0]));
      chk($sformatf("R2 vec%0d grant count", v), 32'($countones(grant_a) <= 1), 32'h1);
      req_a  = VEC[v][13:10];
      want_a = VEC[v][9:6];
    end

    // R1: reset during a hand-over returns the grant to master 0
    @(negedge clk);
    req_a = 4'b0100;
    @(negedge clk);
    chk("R4 swap before reset", 32'(grant_a), 32'h4);
    rst_n = 1'b0;
    req_a = '0;
    #1;
    chk("R1 grant on mid-run reset", 32'(grant_a), 32'h1);
    chk("R1 ack on mid-run reset", 32'(ack_a), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after release", 32'(grant_a), 32'h1);

    chk("R10 overlapping starts", 32'(overlap_a), 32'h0);

    // Second instance: ACK_LAT=2, GRANT_SLIP=1
    step_b(4'b0001, 1'b0, 1'b0, 4'b0010, 4'b0001, "R3 b1");
    step_b(4'b0010, 1'b1, 1'b0, 4'b0000, 4'b0010, "R4 b2");
    step_b(4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0010, "R5 b3");
    step_b(4'b0000, 1'b0, 1'b1, 4'b0000, 4'b0010, "R7 b4");
    step_b(4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0010, "R6 b5");
    step_b(4'b0010, 1'b0, 1'b0, 4'b0000, 4'b0010, "R6 b6");
    step_b(4'b0010, 1'b1, 1'b0, 4'b0001, 4'b0000, "R11 b7");
    step_b(4'b0010, 1'b0, 1'b0, 4'b0001, 4'b0000, "R11 b8");
    step_b(4'b0001, 1'b0, 1'b1, 4'b0000, 4'b0000, "R7 b9");
    step_b(4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0000, "R5 b10");
    step_b(4'b0001, 1'b0, 1'b0, 4'b0000, 4'b0000, "R6 b11");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule